// File: doc/BRIEF.md
# Shared Chunk-Pool Packet Buffer

This block is the central packet store of a small cut-through switch with eight ports on one clock. All storage sits in one pool of 128 chunks of eight bytes, and every output port draws from that pool. An input port offers one byte per cycle, together with the number of the output it targets. Once the input wins that output, it writes its packet into chunks taken from the pool. Each chunk is linked onto the tail of a queue that belongs to the target output. Each output reads its queue in order, one byte per cycle, and flags the last byte of every packet. A chunk goes back to the pool as soon as its last useful byte has been read.

The first byte of every packet is a length byte. Its value is the number of bytes in the packet, the length byte included, and is always below 255. Every packet starts in a fresh chunk. An output locks to a single input for the whole of a packet, so packets never interleave on an output. When several inputs wait for the same idle output, the input that was granted that output least recently wins. Bytes flow to the output as soon as they are written, so a packet can begin leaving before its tail has arrived.

Top module: `chunk_pool_switch`

## Requirements
- R1: In the first cycle after reset every `out_valid` and every `in_ready` is 0. All 128 chunks start in the pool.
- R2: A packet is delivered byte for byte, length byte first. `out_eop` is 1 on its last byte only. A length value of 0 or 1 makes a one-byte packet.
- R3: An idle output raises `out_valid`, with the length byte on `out_data`, in the cycle after that byte is accepted at the input. It never raises `out_valid` earlier.
- R4: Among inputs waiting for an idle output, the one granted that output least recently wins. Before any grant, lower input numbers count as less recently served. An output stays locked to one input until that input's packet is complete, so packets never interleave.
- R5: Every packet begins in a new chunk. With an output not drained, 128 packets of 8 bytes each are accepted. The next packet's `in_ready` then stays 0.
- R6: A chunk returns to the pool when its last useful byte is read. A stalled input raises `in_ready` within 3 cycles of that read.
- R7: A stalled output does not hold back traffic between other inputs and outputs.
- R8: A 254-byte packet crossing 32 chunks arrives intact, even with idle cycles in `in_valid`. Packets from one input to one output leave in arrival order.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_eop` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 8 | Per input: a byte is offered |
| in_data | input | 64 | Per input: offered byte, input n in bits 8n+7..8n |
| in_dest | input | 24 | Per input: target output, input n in bits 3n+2..3n |
| in_ready | output | 8 | Per input: the offered byte is taken at this edge |
| out_valid | output | 8 | Per output: a byte is available |
| out_data | output | 64 | Per output: byte, output n in bits 8n+7..8n |
| out_eop | output | 8 | Per output: the current byte ends its packet |
| out_ready | input | 8 | Per output: the consumer takes the byte |

## Verification
A broken link or head pointer shows up at an output as bytes from the wrong chunk. This appears within the first eight bytes after the faulty chunk boundary. A chunk lost from the pool appears as a missing `in_ready` in the capacity test, at the 128th packet. A chunk handed out twice corrupts a packet that is still queued, and the corruption appears on its next read. A wrong arbitration order changes which packet arrives first at a contended output. A leaked lock leaves that output silent after the current packet ends.

// File: rtl/chunk_pool_switch.sv
module chunk_pool_switch #(
  parameter int NP = 8,
  parameter int NCHUNK = 128,
  parameter int CB = 8,
  localparam int PW = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    in_valid,
  input  logic [NP*8-1:0]  in_data,
  input  logic [NP*PW-1:0] in_dest,
  output logic [NP-1:0]    in_ready,
  output logic [NP-1:0]    out_valid,
  output logic [NP*8-1:0]  out_data,
  output logic [NP-1:0]    out_eop,
  input  logic [NP-1:0]    out_ready
);
  localparam int CW = $clog2(NCHUNK);
  localparam int OW = $clog2(CB);
  localparam int AW = $clog2(NCHUNK*CB+1);

  logic [7:0]        mem [NCHUNK*CB];
  logic [CW-1:0]     nxt [NCHUNK];
  logic [NCHUNK-1:0] free_q, free_d;

  logic [NP-1:0] act, spv, wfire, wnew, wlast, ig, areq;
  logic [CW-1:0] spare [NP], cur [NP], wchunk [NP];
  logic [OW-1:0] woff [NP];
  logic [7:0]    wrem [NP], ibyte [NP];
  logic [PW-1:0] wdst [NP], idst [NP];

  logic [NP-1:0] own_v, gnt_v, qnv, rfire, rpop, reop, pv, inc;
  logic [PW-1:0] own_id [NP], gnt_id [NP], gnt_pos [NP];
  logic [PW-1:0] order [NP][NP];
  logic [CW-1:0] head [NP], tail [NP], pc [NP];
  logic [OW-1:0] roff [NP];
  logic [7:0]    rrem [NP], rbyte [NP];
  logic [AW-1:0] ravail [NP];
  logic [NP-1:0] own_vec [NP];

  logic [PW-1:0] asel;
  logic          aany, fany;
  logic [CW-1:0] fc;

  for (genvar g = 0; g < NP; g++) begin : g_port
    assign ibyte[g]  = in_data[g*8 +: 8];
    assign idst[g]   = in_dest[g*PW +: PW];
    assign in_ready[g] = act[g] && (woff[g] != '0 || spv[g]);
    assign wfire[g]  = in_valid[g] && in_ready[g];
    assign wnew[g]   = wfire[g] && woff[g] == '0;
    assign wchunk[g] = (woff[g] == '0) ? spare[g] : cur[g];
    assign wlast[g]  = (wrem[g] == 8'd0) ? (ibyte[g] <= 8'd1) : (wrem[g] == 8'd1);

    assign rbyte[g]     = mem[{head[g], roff[g]}];
    assign out_valid[g] = ravail[g] != '0;
    assign reop[g]      = (rrem[g] == 8'd0) ? (rbyte[g] <= 8'd1) : (rrem[g] == 8'd1);
    assign rfire[g]     = out_valid[g] && out_ready[g];
    assign rpop[g]      = rfire[g] && (reop[g] || roff[g] == OW'(CB-1));
    assign out_data[g*8 +: 8] = rbyte[g];
    assign out_eop[g]   = reop[g];

    assign pv[g]  = own_v[g] && wnew[own_id[g]];
    assign inc[g] = own_v[g] && wfire[own_id[g]];
    assign pc[g]  = spare[own_id[g]];

    p_ready_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[g] |-> own_v[wdst[g]] && own_id[wdst[g]] == PW'(g));
    p_single_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(own_vec[g]));
    p_linked_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[g] |-> qnv[g]);
    p_spare_out_of_pool_r5: assert property (@(posedge clk) disable iff (!rst_n)
      spv[g] |-> !free_q[spare[g]]);
    p_head_out_of_pool_r6: assert property (@(posedge clk) disable iff (!rst_n)
      qnv[g] |-> !free_q[head[g]]);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[g] && !out_ready[g] |=> out_valid[g] && $stable(out_data[g*8 +: 8]) && $stable(out_eop[g]));
  end

  always_comb begin
    ig = '0;
    for (int o = 0; o < NP; o++) begin
      gnt_v[o] = 1'b0;
      gnt_id[o] = '0;
      gnt_pos[o] = '0;
      for (int k = NP-1; k >= 0; k--) begin
        if (!own_v[o] && in_valid[order[o][k]] && !act[order[o][k]] &&
            idst[order[o][k]] == PW'(o)) begin
          gnt_v[o] = 1'b1;
          gnt_id[o] = order[o][k];
          gnt_pos[o] = PW'(k);
        end
      end
      if (gnt_v[o]) ig[gnt_id[o]] = 1'b1;
      for (int i = 0; i < NP; i++) own_vec[o][i] = act[i] && wdst[i] == PW'(o);
    end
  end

  always_comb begin
    aany = 1'b0;
    asel = '0;
    for (int i = NP-1; i >= 0; i--) begin
      areq[i] = !spv[i] && ((act[i] && woff[i] == '0) || (in_valid[i] && !act[i]));
      if (areq[i]) begin
        aany = 1'b1;
        asel = PW'(i);
      end
    end
    fany = |free_q;
    fc = '0;
    for (int c = NCHUNK-1; c >= 0; c--) if (free_q[c]) fc = CW'(c);
    free_d = free_q;
    if (aany && fany) free_d[fc] = 1'b0;
    for (int o = 0; o < NP; o++) if (rpop[o]) free_d[head[o]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++)
      if (wfire[i]) mem[{wchunk[i], woff[i]}] <= ibyte[i];
    for (int o = 0; o < NP; o++)
      if (pv[o] && qnv[o]) nxt[tail[o]] <= pc[o];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= '1;
      act <= '0;
      spv <= '0;
      own_v <= '0;
      qnv <= '0;
      for (int i = 0; i < NP; i++) begin
        spare[i] <= '0;
        cur[i] <= '0;
        woff[i] <= '0;
        wrem[i] <= '0;
        wdst[i] <= '0;
        own_id[i] <= '0;
        head[i] <= '0;
        tail[i] <= '0;
        roff[i] <= '0;
        rrem[i] <= '0;
        ravail[i] <= '0;
        for (int k = 0; k < NP; k++) order[i][k] <= PW'(k);
      end
    end else begin
      free_q <= free_d;
      for (int i = 0; i < NP; i++) begin
        if (ig[i]) begin
          act[i] <= 1'b1;
          wdst[i] <= idst[i];
          woff[i] <= '0;
          wrem[i] <= '0;
        end
        if (wfire[i]) begin
          cur[i] <= wchunk[i];
          if (wlast[i]) begin
            act[i] <= 1'b0;
            woff[i] <= '0;
            wrem[i] <= '0;
          end else begin
            woff[i] <= woff[i] + 1'b1;
            wrem[i] <= (wrem[i] == 8'd0) ? ibyte[i] - 8'd1 : wrem[i] - 8'd1;
          end
        end
        if (aany && fany && asel == PW'(i)) begin
          spv[i] <= 1'b1;
          spare[i] <= fc;
        end else if (wnew[i]) begin
          spv[i] <= 1'b0;
        end
      end
      for (int o = 0; o < NP; o++) begin
        if (gnt_v[o]) begin
          own_v[o] <= 1'b1;
          own_id[o] <= gnt_id[o];
          for (int k = 0; k < NP-1; k++)
            if (PW'(k) >= gnt_pos[o]) order[o][k] <= order[o][k+1];
          order[o][NP-1] <= gnt_id[o];
        end else if (own_v[o] && wfire[own_id[o]] && wlast[own_id[o]]) begin
          own_v[o] <= 1'b0;
        end

        if (rpop[o]) begin
          if (head[o] == tail[o]) begin
            if (pv[o]) begin
              head[o] <= pc[o];
              tail[o] <= pc[o];
            end else begin
              qnv[o] <= 1'b0;
            end
          end else begin
            head[o] <= nxt[head[o]];
            if (pv[o]) tail[o] <= pc[o];
          end
        end else if (pv[o]) begin
          tail[o] <= pc[o];
          if (!qnv[o]) begin
            head[o] <= pc[o];
            qnv[o] <= 1'b1;
          end
        end

        ravail[o] <= ravail[o] + AW'(inc[o]) - AW'(rfire[o]);
        if (rfire[o]) begin
          if (reop[o]) begin
            roff[o] <= '0;
            rrem[o] <= '0;
          end else begin
            roff[o] <= roff[o] + 1'b1;
            rrem[o] <= (rrem[o] == 8'd0) ? rbyte[o] - 8'd1 : rrem[o] - 8'd1;
          end
        end
      end
    end
  end
endmodule

// File: tb/chunk_pool_switch_tb.sv
module chunk_pool_switch_tb_top;
  localparam int NP = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n = 1'b0;

  logic ivu [NP];
  logic rdu [NP];
  logic [7:0] id8 [NP];
  logic [2:0] idst [NP];
  logic [7:0] od8 [NP];
  logic [NP-1:0] iv, ir, ov, oe, ordy;
  logic [NP*8-1:0] in_data_f, out_data_f;
  logic [NP*3-1:0] in_dest_f;

  for (genvar g = 0; g < NP; g++) begin : g_flat
    assign iv[g] = ivu[g];
    assign ordy[g] = rdu[g];
    assign in_data_f[g*8 +: 8] = id8[g];
    assign in_dest_f[g*3 +: 3] = idst[g];
    assign od8[g] = out_data_f[g*8 +: 8];
  end

  chunk_pool_switch dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iv), .in_data(in_data_f), .in_dest(in_dest_f), .in_ready(ir),
    .out_valid(ov), .out_data(out_data_f), .out_eop(oe), .out_ready(ordy)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] pl(int seed, int k);
    return 8'(seed + k*7 + k*k);
  endfunction

  task automatic send(int i, int d, int len, int seed, bit gaps);
    int n = (len <= 1) ? 1 : len;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ivu[i] = 1'b1;
      id8[i] = (k == 0) ? 8'(len) : pl(seed, k);
      idst[i] = 3'(d);
      while (!ir[i]) @(negedge clk);
      if (gaps && (k % 5) == 4) begin
        @(negedge clk);
        ivu[i] = 1'b0;
      end
    end
    @(negedge clk);
    ivu[i] = 1'b0;
  endtask

  task automatic recv(int o, int len, int seed, string req, bit stall);
    int n = (len <= 1) ? 1 : len;
    int k = 0;
    int cnt = 0;
    bit dok = 1, eok = 1, hok = 1, held = 0;
    int da = 0, de = 0;
    logic [7:0] hd;
    logic he;
    while (k < n) begin
      @(negedge clk);
      if (held) begin
        if (!(ov[o] && od8[o] == hd && oe[o] == he)) hok = 0;
        held = 0;
      end
      rdu[o] = stall ? ((cnt % 3) != 2) : 1'b1;
      cnt++;
      if (ov[o]) begin
        if (rdu[o]) begin
          logic [7:0] exp = (k == 0) ? 8'(len) : pl(seed, k);
          if (od8[o] != exp && dok) begin
            dok = 0; da = od8[o]; de = exp;
          end
          if (oe[o] != (k == n-1)) eok = 0;
          k++;
        end else begin
          held = 1; hd = od8[o]; he = oe[o];
        end
      end
    end
    @(negedge clk);
    rdu[o] = 1'b0;
    chk(dok, {req, " data"}, da, de);
    chk(eok, "R2 eop placement", 0, 1);
    if (stall) chk(hok, "R9 hold under stall", 0, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ov == '0, "R1 out_valid after reset", int'(ov), 0);
    chk(ir == '0, "R1 in_ready after reset", int'(ir), 0);
  endtask

  task automatic t_cut();
    @(negedge clk);
    ivu[0] = 1'b1; id8[0] = 8'd1; idst[0] = 3'd1;
    chk(ov[1] == 1'b0, "R3 idle before request", int'(ov[1]), 0);
    while (!ir[0]) @(negedge clk);
    chk(ov[1] == 1'b0, "R3 no output before header", int'(ov[1]), 0);
    @(negedge clk);
    ivu[0] = 1'b0;
    chk(ov[1] == 1'b1 && od8[1] == 8'd1, "R3 header one cycle later", int'(od8[1]), 1);
    chk(oe[1] == 1'b1, "R2 length 1 is single byte", int'(oe[1]), 1);
    recv(1, 1, 0, "R2 len1", 0);
    chk(ov[1] == 1'b0, "R2 nothing after single byte", int'(ov[1]), 0);
    fork
      send(0, 1, 0, 0, 0);
      recv(1, 0, 0, "R2 len0", 0);
    join
  endtask

  task automatic t_pool();
    bit s_done = 0;
    bit got = 0;
    fork
      for (int p = 0; p < 128; p++) send(4, 3, 8, p, 0);
    join
    chk(ov[3] == 1'b1, "R5 pool filled and queued", int'(ov[3]), 1);
    fork
      begin
        send(4, 3, 8, 200, 0);
        s_done = 1;
      end
    join_none
    repeat (20) @(negedge clk);
    chk(ir[4] == 1'b0, "R5 ready low with empty pool", int'(ir[4]), 0);
    recv(3, 8, 0, "R5 first pooled packet", 0);
    for (int w = 0; w < 3 && !got; w++) begin
      if (ir[4]) got = 1;
      else @(negedge clk);
    end
    chk(got, "R6 ready after chunk freed", int'(got), 1);
    for (int p = 1; p < 128; p++) recv(3, 8, p, "R5 pooled packet", 0);
    recv(3, 8, 200, "R6 packet after refill", 0);
    wait (s_done);
  endtask

  task automatic t_basic();
    fork
      begin
        send(2, 6, 20, 5, 0);
        send(2, 6, 9, 6, 0);
      end
      begin
        recv(6, 20, 5, "R8 first of pair", 0);
        recv(6, 9, 6, "R8 second of pair", 0);
      end
    join
  endtask

  task automatic t_lru();
    fork
      send(1, 5, 12, 11, 0);
      send(2, 5, 12, 22, 0);
      send(3, 5, 12, 33, 0);
      begin
        recv(5, 12, 11, "R4 first grant input1", 0);
        recv(5, 12, 22, "R4 second grant input2", 0);
        recv(5, 12, 33, "R4 third grant input3", 0);
      end
    join
    // fixed index priority would serve input 1 here; least recently served is input 4
    fork
      send(1, 5, 10, 44, 0);
      send(4, 5, 10, 55, 0);
      begin
        recv(5, 10, 55, "R4 LRU picks input4", 0);
        recv(5, 10, 44, "R4 then input1", 0);
      end
    join
  endtask

  task automatic t_parallel();
    fork
      send(0, 0, 30, 60, 0);
      send(1, 1, 30, 70, 0);
      recv(1, 30, 70, "R7 flowing output", 0);
    join
    chk(ov[0] == 1'b1, "R7 stalled output still holds data", int'(ov[0]), 1);
    recv(0, 30, 60, "R7 stalled output drained", 0);
  endtask

  task automatic t_long();
    fork
      send(7, 2, 254, 90, 1);
      recv(2, 254, 90, "R8 long packet", 1);
    join
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      ivu[i] = 1'b0; rdu[i] = 1'b0; id8[i] = '0; idst[i] = '0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cut();
    t_pool();
    t_basic();
    t_lru();
    t_parallel();
    t_long();
    repeat (5) @(negedge clk);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end
endmodule